// File: doc/BRIEF.md
# PLL Power-Up Sequencing Controller

This block drives the three mode lines of an analog PLL and brings it up and down in a safe order. When the PLL is fully off, an enable request first takes it out of bypass. After a programmable settle gap it releases the PLL reset. It then waits for lock before it switches the output on. The wait for lock either polls a lock input, with a timeout, or runs for a fixed time; a parameter picks which. A disable request clears all three mode lines in a single cycle.

A rate-change request carries a target output rate. The block works out the integer multiplier by dividing the target by the reference rate. It picks the high VCO range when the target is strictly above a threshold. If the PLL is running at that moment, the block shuts it down, applies the new settings and runs the whole power-up sequence again. The fractional numerator and denominator are set once, to 0 and 1 for integer mode, when the first enable is accepted. All delays are counted in clock cycles, derived from a clock-frequency parameter given in MHz.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset, mode_o is 000, and busy_o, err_o, enabled_o, mult_o, vco_hi_o, frac_num_o and frac_den_o are all 0.
- R2: An accepted enable steps mode_o through 000, 010, 110 and 111 in that order. Bit 0 turns the output on, bit 1 high means not bypassed, and bit 2 high means reset released. mode_o shows 010 in the cycle after the request.
- R3: mode_o stays at 010 for exactly SETTLE_US*CLK_MHZ cycles (1000 by default) before it becomes 110. Elaboration rejects a SETTLE_US below 5.
- R4: In lock-polling mode (USE_LOCK=1), mode_o stays at 110 while pll_lock is low. It becomes 111 in the cycle after pll_lock is sampled high.
- R5: In fixed-wait mode (USE_LOCK=0), mode_o becomes 111 exactly FIXED_WAIT_US*CLK_MHZ cycles after it became 110, whatever pll_lock does.
- R6: In lock-polling mode, if lock does not arrive within LOCK_TIMEOUT_US*CLK_MHZ cycles of mode_o becoming 110, mode_o returns to 000, err_o rises and busy_o falls. The next accepted enable clears err_o.
- R7: A dis_req while mode_o is 111 makes mode_o 000 in the next cycle.
- R8: enabled_o is high exactly when mode_o is 111. An en_req is acted on only when mode_o is 000; an en_req while the PLL is on changes nothing.
- R9: A rate request sets mult_o to rate_target/REF_RATE, rounded down, and sets vco_hi_o to (rate_target > VCO_THRESH). Both take effect in the next cycle. When the PLL is off, mode_o stays at 000.
- R10: A rate request while mode_o is 111 gives mode_o 000 in the next cycle, with the new mult_o and vco_hi_o. The cycle after that gives 010, and the full enable sequence follows.
- R11: frac_den_o reads 0 until the first accepted enable. From that enable on, frac_num_o is 0 and frac_den_o is 1.
- R12: busy_o is high from the cycle after an accepted enable or running rate change until mode_o reaches 111 or 000. en_req, dis_req and rate_req are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Power-up request, one cycle |
| dis_req | input | 1 | Power-down request, one cycle |
| rate_req | input | 1 | Rate-change request, one cycle |
| rate_target | input | RATE_W | Target rate in reference units (MHz) |
| pll_lock | input | 1 | Lock indication from the PLL |
| mode_o | output | 3 | PLL mode lines: [0] output on, [1] bypass off, [2] reset released |
| mult_o | output | MULT_W | Integer multiplier |
| vco_hi_o | output | 1 | High VCO range select |
| frac_num_o | output | FRAC_W | Fractional numerator |
| frac_den_o | output | FRAC_W | Fractional denominator |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Lock timed out |
| enabled_o | output | 1 | PLL fully on |

## Verification
The hardest case to reach from the ports is a lock timeout, and the re-enable that must clear the error after it. The bench holds pll_lock low through a full enable and counts the cycles from mode 110 back to 000. It then starts a fresh sequence and checks that err_o drops. A second case is the restart wrapped around a rate change, which needs the PLL fully on first. For that, the bench keeps lock high after a completed power-up and issues the rate request from the on state. A second instance built with the fixed wait checks that variant's timing.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   localparam int MB_OUT = 0;
   localparam int MB_BYP = 1;
   localparam int MB_RST = 2;

   localparam logic [2:0] MODE_OFF = 3'b000;
   localparam logic [2:0] MODE_BYP = 3'b010;
   localparam logic [2:0] MODE_REL = 3'b110;
   localparam logic [2:0] MODE_ON  = 3'b111;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_SETTLE,
      ST_LOCKWAIT,
      ST_ON,
      ST_RESTART
   } seq_state_e;
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // the counter never moves upward unless it is reloaded
   a_r3_timer_down : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
   parameter int RATE_W     = 16,
   parameter int MULT_W     = 12,
   parameter int REF_RATE   = 19,
   parameter int VCO_THRESH = 1200
) (
   input  logic [RATE_W-1:0] target,
   output logic [MULT_W-1:0] mult,
   output logic              vco_hi
);
   localparam int MAX_QUOT = ((2 ** RATE_W) - 1) / REF_RATE;

   generate
      if (REF_RATE < 1) begin : g_bad_ref
         $error("REF_RATE must be positive");
      end
      if (MAX_QUOT >= (2 ** MULT_W)) begin : g_bad_mult
         $error("MULT_W too narrow for the largest quotient");
      end
   endgenerate

   logic [RATE_W-1:0] quot;
   assign quot   = target / RATE_W'(REF_RATE);
   assign mult   = MULT_W'(quot);
   assign vco_hi = (target > RATE_W'(VCO_THRESH));
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
   import pll_seq_pkg::*;
#(
   parameter int CLK_MHZ         = 100,
   parameter int SETTLE_US       = 10,
   parameter int FIXED_WAIT_US   = 60,
   parameter int LOCK_TIMEOUT_US = 200,
   parameter bit USE_LOCK        = 1'b1,
   parameter int RATE_W          = 16,
   parameter int MULT_W          = 12,
   parameter int FRAC_W          = 16,
   parameter int REF_RATE        = 19,
   parameter int VCO_THRESH      = 1200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_req,
   input  logic              dis_req,
   input  logic              rate_req,
   input  logic [RATE_W-1:0] rate_target,
   input  logic              pll_lock,
   output logic [2:0]        mode_o,
   output logic [MULT_W-1:0] mult_o,
   output logic              vco_hi_o,
   output logic [FRAC_W-1:0] frac_num_o,
   output logic [FRAC_W-1:0] frac_den_o,
   output logic              busy_o,
   output logic              err_o,
   output logic              enabled_o
);
   localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
   localparam int WAIT_CYC   = USE_LOCK ? LOCK_TIMEOUT_US * CLK_MHZ : FIXED_WAIT_US * CLK_MHZ;
   localparam int MAX_CYC    = (SETTLE_CYC > WAIT_CYC) ? SETTLE_CYC : WAIT_CYC;
   localparam int CNT_W      = $clog2(MAX_CYC + 1);

   generate
      if (SETTLE_US < 5) begin : g_bad_settle
         $error("bypass-to-reset gap must be at least 5 us");
      end
      if (CLK_MHZ < 1 || WAIT_CYC < 1) begin : g_bad_wait
         $error("clock frequency and wait time must be positive");
      end
   endgenerate

   seq_state_e        state_q;
   logic [2:0]        mode_q;
   logic              tmr_load, tmr_exp;
   logic [CNT_W-1:0]  tmr_val;
   logic              wait_ok, wait_fail;
   logic [MULT_W-1:0] calc_mult;
   logic              calc_hi;
   logic              en_take;

   pll_rate_calc #(
      .RATE_W(RATE_W), .MULT_W(MULT_W), .REF_RATE(REF_RATE), .VCO_THRESH(VCO_THRESH)
   ) u_rate (
      .target(rate_target), .mult(calc_mult), .vco_hi(calc_hi)
   );

   pll_seq_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
   );

   // wait-for-lock variant
   generate
      if (USE_LOCK) begin : g_poll
         assign wait_ok   = pll_lock;
         assign wait_fail = tmr_exp;
      end else begin : g_fixed
         logic unused_lock;
         assign unused_lock = pll_lock;
         assign wait_ok     = tmr_exp;
         assign wait_fail   = 1'b0;
      end
   endgenerate

   assign en_take = (state_q == ST_OFF) && !rate_req && en_req && (mode_q == MODE_OFF);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = CNT_W'(SETTLE_CYC - 1);
      if (en_take || state_q == ST_RESTART) begin
         tmr_load = 1'b1;
      end else if (state_q == ST_SETTLE && tmr_exp) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(WAIT_CYC - 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_OFF;
         mode_q     <= MODE_OFF;
         mult_o     <= '0;
         vco_hi_o   <= 1'b0;
         frac_num_o <= '0;
         frac_den_o <= '0;
         err_o      <= 1'b0;
      end else begin
         case (state_q)
            ST_OFF: begin
               if (rate_req) begin
                  mult_o   <= calc_mult;
                  vco_hi_o <= calc_hi;
               end else if (en_take) begin
                  frac_num_o <= '0;
                  frac_den_o <= FRAC_W'(1);
                  err_o      <= 1'b0;
                  mode_q     <= MODE_BYP;
                  state_q    <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (tmr_exp) begin
                  mode_q  <= MODE_REL;
                  state_q <= ST_LOCKWAIT;
               end
            end
            ST_LOCKWAIT: begin
               if (wait_ok) begin
                  mode_q  <= MODE_ON;
                  state_q <= ST_ON;
               end else if (wait_fail) begin
                  mode_q  <= MODE_OFF;
                  err_o   <= 1'b1;
                  state_q <= ST_OFF;
               end
            end
            ST_ON: begin
               if (dis_req) begin
                  mode_q  <= MODE_OFF;
                  state_q <= ST_OFF;
               end else if (rate_req) begin
                  mode_q   <= MODE_OFF;
                  mult_o   <= calc_mult;
                  vco_hi_o <= calc_hi;
                  state_q  <= ST_RESTART;
               end
            end
            ST_RESTART: begin
               mode_q  <= MODE_BYP;
               state_q <= ST_SETTLE;
            end
            default: begin
               mode_q  <= MODE_OFF;
               state_q <= ST_OFF;
            end
         endcase
      end
   end

   assign mode_o    = mode_q;
   assign busy_o    = (state_q != ST_OFF) && (state_q != ST_ON);
   assign enabled_o = (mode_q == MODE_ON);

   // checking logic: cycles spent in bypass-off, reset-held
   logic [CNT_W-1:0] byp_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         byp_cnt <= '0;
      else if (mode_q != MODE_BYP)
         byp_cnt <= '0;
      else if (byp_cnt != {CNT_W{1'b1}})
         byp_cnt <= byp_cnt + 1'b1;
   end

   a_r2_legal_mode : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_OFF) || (mode_o == MODE_BYP) || (mode_o == MODE_REL) || (mode_o == MODE_ON));

   a_r2_out_after_release : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_o[MB_OUT]) |-> ($past(mode_o[MB_RST]) && $past(mode_o[MB_BYP])));

   a_r3_min_gap : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_o[MB_RST]) |-> ($past(byp_cnt) >= CNT_W'(SETTLE_CYC - 1)));

   a_r6_err_off : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (mode_o == MODE_OFF && !busy_o));

   a_r7_disable : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_ON && dis_req) |=> (mode_o == MODE_OFF));

   a_r12_busy_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && rate_req) |=> $stable(mult_o));
endmodule

// File: tb/test_pll_seq_ctrl.sv
module test_pll_seq_ctrl;
   localparam int CLK_MHZ = 100;
   localparam int SET_CYC = 1000;
   localparam int FIX_CYC = 6000;
   localparam int TMO_CYC = 2000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        en, dis, rreq, lock;
   logic [15:0] tgt;
   logic [2:0]  mode;
   logic [11:0] mult;
   logic        vhi, busy, err, ena;
   logic [15:0] fnum, fden;

   logic        f_en;
   logic [2:0]  f_mode;
   logic [11:0] f_mult;
   logic        f_vhi, f_busy, f_err, f_ena;
   logic [15:0] f_num, f_den;

   int total = 0;
   int bad = 0;

   pll_seq_ctrl #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(10), .LOCK_TIMEOUT_US(20), .USE_LOCK(1'b1))
   i_pll_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .en_req(en), .dis_req(dis), .rate_req(rreq),
      .rate_target(tgt), .pll_lock(lock), .mode_o(mode), .mult_o(mult), .vco_hi_o(vhi),
      .frac_num_o(fnum), .frac_den_o(fden), .busy_o(busy), .err_o(err), .enabled_o(ena));

   pll_seq_ctrl #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(10), .FIXED_WAIT_US(60), .USE_LOCK(1'b0))
   i_pll_seq_ctrl_fix (
      .clk(clk), .rst_n(rst_n), .en_req(f_en), .dis_req(1'b0), .rate_req(1'b0),
      .rate_target(16'd0), .pll_lock(1'b0), .mode_o(f_mode), .mult_o(f_mult), .vco_hi_o(f_vhi),
      .frac_num_o(f_num), .frac_den_o(f_den), .busy_o(f_busy), .err_o(f_err), .enabled_o(f_ena));

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_mode(input bit fix, input logic [2:0] m, output int n);
      n = 0;
      while (((fix ? f_mode : mode) != m) && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset;
      check("R1 mode", mode, 0);
      check("R1 busy", busy, 0);
      check("R1 err", err, 0);
      check("R1 ena", ena, 0);
      check("R1 mult", mult, 0);
      check("R1 vco", vhi, 0);
      check("R1 num", fnum, 0);
      check("R1 den", fden, 0);
   endtask

   task automatic t_rate_off;
      tgt = 16'd1200; rreq = 1'b1;
      @(negedge clk); rreq = 1'b0;
      check("R9 mult at threshold", mult, 63);
      check("R9 vco at threshold", vhi, 0);
      check("R9 mode stays off", mode, 0);
      tgt = 16'd1201; rreq = 1'b1;
      @(negedge clk); rreq = 1'b0;
      check("R9 mult above", mult, 63);
      check("R9 vco above", vhi, 1);
      check("R11 den before enable", fden, 0);
      check("R12 not busy", busy, 0);
   endtask

   task automatic t_enable_lock;
      int n;
      lock = 1'b0; en = 1'b1;
      @(negedge clk); en = 1'b0;
      check("R2 bypass off first", mode, 3'b010);
      check("R12 busy", busy, 1);
      check("R11 num", fnum, 0);
      check("R11 den", fden, 1);
      // requests while busy are ignored
      tgt = 16'd1536; rreq = 1'b1; dis = 1'b1;
      @(negedge clk); rreq = 1'b0; dis = 1'b0;
      check("R12 ignored mode", mode, 3'b010);
      check("R12 ignored mult", mult, 63);
      wait_mode(1'b0, 3'b110, n);
      check("R3 settle gap", n + 1, SET_CYC);
      repeat (3) @(negedge clk);
      check("R4 holds without lock", mode, 3'b110);
      lock = 1'b1;
      @(negedge clk);
      check("R4 on after lock", mode, 3'b111);
      check("R8 enabled", ena, 1);
      check("R12 busy done", busy, 0);
   endtask

   task automatic t_en_when_on;
      en = 1'b1;
      @(negedge clk); en = 1'b0;
      check("R8 enable ignored when on", mode, 3'b111);
      check("R8 no busy", busy, 0);
   endtask

   task automatic t_rate_running;
      int n;
      tgt = 16'd960; rreq = 1'b1;
      @(negedge clk); rreq = 1'b0;
      check("R10 off first", mode, 3'b000);
      check("R9 mult new", mult, 50);
      check("R9 vco low", vhi, 0);
      check("R10 busy", busy, 1);
      check("R8 not enabled", ena, 0);
      @(negedge clk);
      check("R10 bypass off", mode, 3'b010);
      wait_mode(1'b0, 3'b110, n);
      check("R10 settle again", n, SET_CYC);
      @(negedge clk);
      check("R10 back on", mode, 3'b111);
   endtask

   task automatic t_disable;
      dis = 1'b1;
      @(negedge clk); dis = 1'b0;
      check("R7 all clear", mode, 3'b000);
      check("R7 not busy", busy, 0);
   endtask

   task automatic t_timeout;
      int n;
      lock = 1'b0; en = 1'b1;
      @(negedge clk); en = 1'b0;
      wait_mode(1'b0, 3'b110, n);
      wait_mode(1'b0, 3'b000, n);
      check("R6 timeout length", n, TMO_CYC);
      check("R6 err", err, 1);
      check("R6 not busy", busy, 0);
      en = 1'b1;
      @(negedge clk); en = 1'b0;
      check("R6 err cleared", err, 0);
      check("R6 restarted", mode, 3'b010);
      wait_mode(1'b0, 3'b110, n);
      lock = 1'b1;
      @(negedge clk);
      check("R4 on again", mode, 3'b111);
      dis = 1'b1;
      @(negedge clk); dis = 1'b0;
      check("R7 off again", mode, 3'b000);
   endtask

   task automatic t_fixed;
      int n;
      f_en = 1'b1;
      @(negedge clk); f_en = 1'b0;
      check("R2 fixed bypass off", f_mode, 3'b010);
      wait_mode(1'b1, 3'b110, n);
      check("R3 fixed settle", n, SET_CYC);
      wait_mode(1'b1, 3'b111, n);
      check("R5 fixed wait", n, FIX_CYC);
      check("R5 no error", f_err, 0);
      check("R8 fixed enabled", f_ena, 1);
   endtask

   initial begin
      en = 0; dis = 0; rreq = 0; lock = 0; tgt = '0; f_en = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rate_off();
      t_enable_lock();
      t_en_when_on();
      t_rate_running();
      t_disable();
      t_timeout();
      t_fixed();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule